// File: doc/BRIEF.md
# Rotating-Drum Program Sequencer

This block models the instruction drum of a very small accumulator machine. A ring of program lines turns one position per enabled step. The block presents the line under the read head to an external decoder, together with two alternating timing lights and a qualifier that says whether the decoder should act on that line. The ring wraps from the last line back to the first.

There is no program counter to load. When the decoder reports an unconditional jump, or a conditional jump whose flag is true, the block keeps turning and skips lines without executing them. It stops skipping at the first line whose address field carries the requested label, a value from 1 to 4, and only if that line's opcode is one that uses its address field as a label. A line can also be marked through a preceding label-marker line. In that case the marker is not executed, and execution resumes at the line right after it. If a search goes all the way round the ring without finding a match, the block halts and flags an error until it is reset.

The program is loaded through a plain write port while stepping is paused.

Top module: `drum_sequencer`

## Requirements
- R1: After reset the head is at line 0. `line_o` shows the stored line 0, `exec_o` is 1, `err_o` is 0, `even_o` is 1 and `odd_o` is 0.
- R2: Each cycle with `step_en`=1 moves the head one line forward, and line 19 is followed by line 0. With `step_en`=0 the head stays where it is.
- R3: `even_o` is 1 and `odd_o` is 0 while the head is on an even-numbered line. The values are swapped on an odd-numbered line.
- R4: A write (`wr_en`=1, index below 20) stores `wr_data` into that line only when `step_en`=0. With `step_en`=1 the write is ignored.
- R5: Line layout: opcode in bits [9:6], address or label in bits [5:2], timing bits in [1:0]. `line_o` always shows the stored line at the head.
- R6: While `exec_o`=1 and no search is running, a step with `jump_req`=1, `jump_cond`=0 and a label of 1 to 4 starts a search. The lines passed during the search show `exec_o`=0.
- R7: With `jump_cond`=1, a jump is taken only when `cond_flag`=1. Otherwise the step is an ordinary advance with `exec_o`=1.
- R8: A search ends on the first line whose opcode is one of 1 to 7 or 15 and whose address field equals the label. That line shows `exec_o`=1. A matching address under any other opcode does not end the search.
- R9: A search line with opcode 14 (label marker) and a matching label shows `exec_o`=0. The next step lands on the following line with `exec_o`=1, whatever that line holds.
- R10: A search that examines 20 lines without a match leaves the head on the last line examined, with `err_o`=1 and `exec_o`=0. The head then stays still until reset, and reset clears the error.
- R11: A jump request with a label outside 1 to 4 is ignored. A jump request made while a search is running is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Turn the drum one line this cycle |
| jump_req | input | 1 | Decoder reports a jump on the current line |
| jump_cond | input | 1 | 1 = conditional jump, 0 = unconditional |
| cond_flag | input | 1 | Condition for a conditional jump |
| jump_label | input | 4 | Target label, valid values 1 to 4 |
| wr_en | input | 1 | Program write strobe |
| wr_idx | input | 5 | Line index to write |
| wr_data | input | 10 | Line contents to write |
| line_o | output | 10 | Line under the head |
| even_o | output | 1 | Even-line timing light |
| odd_o | output | 1 | Odd-line timing light |
| exec_o | output | 1 | Current line is to be executed |
| err_o | output | 1 | A search went a full turn without a match; halted |

## Verification
The hardest state to reach from the ports is the full-turn failure. Getting there needs a loaded program in which no line carries the label, a jump taken from an executing line, and exactly twenty further lines examined before the halt. The program also holds decoys: a matching address under a non-label opcode, and a marker for a different label. These show that only true matches end a search. The bench starts a label-4 search and steps through the whole ring, checking the halted line and the timing lights. It then confirms that further steps and jump requests leave the head frozen until reset.

// File: rtl/drum_pkg.sv
package drum_pkg;
  localparam int OP_W   = 4;
  localparam int ADR_W  = 4;
  localparam int TM_W   = 2;
  localparam int LINE_W = OP_W + ADR_W + TM_W;
  localparam int TAG_W  = OP_W + ADR_W;

  localparam logic [OP_W-1:0]  OP_MARK = 4'hE;
  localparam logic [ADR_W-1:0] LBL_LO  = 4'd1;
  localparam logic [ADR_W-1:0] LBL_HI  = 4'd4;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [ADR_W-1:0] adr;
  } tag_t;

  typedef enum logic [1:0] {
    M_RUN   = 2'd0,
    M_SEEK  = 2'd1,
    M_AFTER = 2'd2,
    M_HALT  = 2'd3
  } mode_t;
endpackage

// File: rtl/drum_store.sv
module drum_store
  import drum_pkg::*;
#(
  parameter int LINES = 20,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LINE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  output logic [LINE_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [TAG_W-1:0]  rtag_b
);
  logic [LINE_W-1:0] ring [LINES];

  always_ff @(posedge clk) begin
    if (we) ring[widx] <= wdata;
  end

  // Two asynchronous read ports: head line and look-ahead tag
  assign rdata_a = ring[ridx_a];
  assign rtag_b  = ring[ridx_b][LINE_W-1:TM_W];
endmodule

// File: rtl/drum_label_match.sv
module drum_label_match
  import drum_pkg::*;
#(
  parameter logic [15:0] LABEL_OPS = 16'h80FE
) (
  input  tag_t             tag,
  input  logic [ADR_W-1:0] label,
  output logic             hit_direct,
  output logic             hit_marker
);
  logic same_lbl;

  always_comb begin
    same_lbl   = (tag.adr == label);
    hit_marker = same_lbl && (tag.op == OP_MARK);
    hit_direct = same_lbl && (tag.op != OP_MARK) && LABEL_OPS[tag.op];
  end
endmodule

// File: rtl/drum_seq_ctrl.sv
module drum_seq_ctrl
  import drum_pkg::*;
#(
  parameter int LINES = 20,
  localparam int IDX_W = $clog2(LINES),
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             jump_req,
  input  logic             jump_cond,
  input  logic             cond_flag,
  input  logic [ADR_W-1:0] jump_label,
  input  logic             hit_direct,
  input  logic             hit_marker,
  output logic [IDX_W-1:0] pos_q,
  output logic [IDX_W-1:0] nxt_idx,
  output logic [ADR_W-1:0] seek_label,
  output logic             exec_o,
  output logic             even_o,
  output logic             odd_o,
  output logic             err_o
);
  mode_t            mode_q;
  logic [ADR_W-1:0] label_q;
  logic [CNT_W-1:0] cnt_q;
  logic             exec_q;
  logic             even_q;
  logic             odd_q;
  logic             label_ok;
  logic             take;
  logic             seeking;
  logic [CNT_W-1:0] cnt_now;

  always_comb begin
    label_ok   = (jump_label >= LBL_LO) && (jump_label <= LBL_HI);
    take       = (mode_q == M_RUN) && exec_q && jump_req && label_ok &&
                 (!jump_cond || cond_flag);
    seeking    = take || (mode_q == M_SEEK);
    seek_label = take ? jump_label : label_q;
    cnt_now    = take ? '0 : cnt_q;
    nxt_idx    = (pos_q == IDX_W'(LINES - 1)) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      mode_q  <= M_RUN;
      label_q <= '0;
      cnt_q   <= '0;
      exec_q  <= 1'b1;
      even_q  <= 1'b1;
      odd_q   <= 1'b0;
    end else if (step_en && (mode_q != M_HALT)) begin
      pos_q  <= nxt_idx;
      even_q <= ~nxt_idx[0];
      odd_q  <= nxt_idx[0];
      if (seeking) begin
        if (take) label_q <= jump_label;
        if (hit_direct) begin
          mode_q <= M_RUN;
          exec_q <= 1'b1;
        end else if (hit_marker) begin
          mode_q <= M_AFTER;
          exec_q <= 1'b0;
        end else begin
          exec_q <= 1'b0;
          if (cnt_now == CNT_W'(LINES - 1)) begin
            mode_q <= M_HALT;
          end else begin
            mode_q <= M_SEEK;
            cnt_q  <= cnt_now + 1'b1;
          end
        end
      end else begin
        mode_q <= M_RUN;
        exec_q <= 1'b1;
      end
    end
  end

  assign exec_o = exec_q;
  assign even_o = even_q;
  assign odd_o  = odd_q;
  assign err_o  = (mode_q == M_HALT);

  // R2
  hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pos_q));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && (mode_q != M_HALT) && (pos_q == IDX_W'(LINES - 1))) |=> (pos_q == '0));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_HALT) |=> ((mode_q == M_HALT) && $stable(pos_q) && !exec_q));

  // R6
  seek_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SEEK) |-> !exec_q);

  // R7
  cond_false_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && (mode_q == M_RUN) && exec_q && jump_req && jump_cond && !cond_flag)
      |=> (exec_q && (mode_q == M_RUN)));

  // R9
  after_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && (mode_q == M_AFTER)) |=> (exec_q && (mode_q == M_RUN)));
endmodule

// File: rtl/drum_sequencer.sv
module drum_sequencer
  import drum_pkg::*;
#(
  parameter int          LINES     = 20,
  parameter logic [15:0] LABEL_OPS = 16'h80FE,
  localparam int         IDX_W     = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              jump_req,
  input  logic              jump_cond,
  input  logic              cond_flag,
  input  logic [ADR_W-1:0]  jump_label,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_data,
  output logic [LINE_W-1:0] line_o,
  output logic              even_o,
  output logic              odd_o,
  output logic              exec_o,
  output logic              err_o
);
  logic             we_ok;
  logic [IDX_W-1:0] pos;
  logic [IDX_W-1:0] nxt;
  logic [TAG_W-1:0] nxt_tag;
  logic [ADR_W-1:0] seek_label;
  logic             hit_direct;
  logic             hit_marker;

  // Loads only while paused and only into lines that exist
  assign we_ok = wr_en && !step_en && (wr_idx < IDX_W'(LINES));

  drum_store #(.LINES(LINES)) store_i (
    .clk     (clk),
    .we      (we_ok),
    .widx    (wr_idx),
    .wdata   (wr_data),
    .ridx_a  (pos),
    .rdata_a (line_o),
    .ridx_b  (nxt),
    .rtag_b  (nxt_tag)
  );

  drum_label_match #(.LABEL_OPS(LABEL_OPS)) match_i (
    .tag        (tag_t'(nxt_tag)),
    .label      (seek_label),
    .hit_direct (hit_direct),
    .hit_marker (hit_marker)
  );

  drum_seq_ctrl #(.LINES(LINES)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .jump_req   (jump_req),
    .jump_cond  (jump_cond),
    .cond_flag  (cond_flag),
    .jump_label (jump_label),
    .hit_direct (hit_direct),
    .hit_marker (hit_marker),
    .pos_q      (pos),
    .nxt_idx    (nxt),
    .seek_label (seek_label),
    .exec_o     (exec_o),
    .even_o     (even_o),
    .odd_o      (odd_o),
    .err_o      (err_o)
  );

  // R4
  paused_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && step_en) |=> $stable(line_o) || $changed(pos));
endmodule

// File: tb/drum_sequencer_tb_top.sv
`timescale 1ns/1ps
module drum_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       step_en, jump_req, jump_cond, cond_flag;
  logic [3:0] jump_label;
  logic       wr_en;
  logic [4:0] wr_idx;
  logic [9:0] wr_data;
  logic [9:0] line_o;
  logic       even_o, odd_o, exec_o, err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  drum_sequencer dut_i (
    .clk(clk), .rst(rst), .step_en(step_en), .jump_req(jump_req),
    .jump_cond(jump_cond), .cond_flag(cond_flag), .jump_label(jump_label),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .line_o(line_o),
    .even_o(even_o), .odd_o(odd_o), .exec_o(exec_o), .err_o(err_o)
  );

  // Test program: opcode [9:6], address [5:2], timing [1:0]
  function automatic logic [9:0] prog(int i);
    logic [3:0] op, ad;
    logic [1:0] tm;
    op = (i >= 16) ? 4'h9 : 4'h0;
    ad = 4'(i % 16);
    tm = (i % 2 == 1) ? 2'b01 : 2'b10;
    case (i)
      3:  begin op = 4'h8; ad = 4'd2; end
      5:  begin op = 4'h1; ad = 4'd2; end
      9:  begin op = 4'hE; ad = 4'd3; end
      10: begin op = 4'h8; ad = 4'd3; end
      14: begin op = 4'hF; ad = 4'd1; end
      default: ;
    endcase
    return {op, ad, tm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_at(string req, int p, logic ex, logic er);
    check({req, " line"}, 32'(line_o), 32'(prog(p)));
    check({req, " exec"}, 32'(exec_o), 32'(ex));
    check({req, " err"},  32'(err_o),  32'(er));
    check("R3 even", 32'(even_o), 32'(p % 2 == 0));
    check("R3 odd",  32'(odd_o),  32'(p % 2 == 1));
  endtask

  task automatic drive(logic se, logic jr, logic jc, logic cf, logic [3:0] lb);
    step_en = se; jump_req = jr; jump_cond = jc; cond_flag = cf; jump_label = lb;
    @(negedge clk);
  endtask

  // {step, jreq, jcond, cond, label[4], exp_pos[5], exp_exec, exp_err}
  localparam int NV = 36;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd1,1'b1,1'b0},   // R2 advance
    {1'b0,1'b0,1'b0,1'b0,4'd0,5'd1,1'b1,1'b0},   // R2 hold
    {1'b1,1'b1,1'b0,1'b0,4'd2,5'd2,1'b0,1'b0},   // R6 take label 2
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd3,1'b0,1'b0},   // R8 decoy op8 addr2
    {1'b1,1'b1,1'b0,1'b0,4'd1,5'd4,1'b0,1'b0},   // R11 request in search
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd5,1'b1,1'b0},   // R8 direct hit
    {1'b1,1'b1,1'b1,1'b0,4'd3,5'd6,1'b1,1'b0},   // R7 cond false
    {1'b1,1'b1,1'b1,1'b1,4'd3,5'd7,1'b0,1'b0},   // R7 cond true
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd8,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd9,1'b0,1'b0},   // R9 marker
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd10,1'b1,1'b0},  // R9 line after marker
    {1'b1,1'b1,1'b0,1'b0,4'd5,5'd11,1'b1,1'b0},  // R11 label 5
    {1'b1,1'b1,1'b0,1'b0,4'd0,5'd12,1'b1,1'b0},  // R11 label 0
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd13,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd14,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd15,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd16,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd17,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd18,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd19,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd0,1'b1,1'b0},   // R2 wrap
    {1'b1,1'b1,1'b0,1'b0,4'd1,5'd1,1'b0,1'b0},   // R6 take label 1
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd2,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd3,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd4,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd5,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd6,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd7,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd8,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd9,1'b0,1'b0},   // R9 other-label marker
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd10,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd11,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd12,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd13,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,4'd0,5'd14,1'b1,1'b0},  // R8 hit at 14
    {1'b1,1'b1,1'b0,1'b0,4'd4,5'd15,1'b0,1'b0}   // R6 take label 4
  };

  task automatic do_reset();
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; step_en = 0; jump_req = 0; jump_cond = 0; cond_flag = 0;
    jump_label = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      wr_en = 1'b1; wr_idx = 5'(i); wr_data = prog(i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    do_reset();
    check_at("R1 reset", 0, 1'b1, 1'b0);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11], VEC[v][10:7]);
      check_at("R2/R5-R11 vector", int'(VEC[v][6:2]), VEC[v][1], VEC[v][0]);
    end

    // R10: rest of the full turn for label 4, then halt on line 14
    for (int k = 0; k < 18; k++) drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    check_at("R10 pre-halt", 13, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    check_at("R10 halted", 14, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 4'd1);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    check_at("R10 frozen", 14, 1'b0, 1'b1);

    // R10/R1: reset clears the error
    do_reset();
    check_at("R10 reset clears", 0, 1'b1, 1'b0);

    // R4: write while stepping is ignored
    wr_en = 1'b1; wr_idx = 5'd0; wr_data = 10'h3C5;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    wr_en = 1'b0;
    check_at("R4 step during write", 1, 1'b1, 1'b0);
    for (int k = 0; k < 19; k++) drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    check_at("R4 ignored write", 0, 1'b1, 1'b0);

    // R4/R5: paused write is visible at the head
    wr_en = 1'b1; wr_idx = 5'd0; wr_data = 10'h3C5;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    wr_en = 1'b0;
    check("R4 paused write", 32'(line_o), 32'h3C5);
    check("R2 paused hold exec", 32'(exec_o), 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule